// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block holds the register file and control logic for one bus-master DMA channel of a SCSI host adapter. Software programs a starting byte count, a starting memory address and a starting descriptor-list address, then writes a command word. A start command copies the starting values into working copies, clears the status bits and enables DMA toward the SCSI core. An idle command drops the enable. An abort command sends a one-cycle cancel pulse to the core.

While the channel is enabled, the SCSI core offers data bursts on a valid/ready handshake. Each burst carries a length and a direction. A burst is accepted when `brst_valid` and `brst_ready` are both high in the same cycle. `brst_ready` is high only while DMA is enabled and no command write is in progress, and the core must hold its request until it sees ready. If the burst direction does not match the programmed direction, the handshake completes but nothing is granted. Otherwise the granted length is the smaller of the requested length and the remaining working count. The grant is returned combinationally in the same cycle, and the working count and working address are advanced at the next edge.

The status register reports when the core finishes a command. A mode input selects how software clears the error, abort and done bits: either it writes ones to them, or reading the status register clears them. The SCSI-interrupt bit is not stored. It is overlaid live from the core's interrupt flag on every status read.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset, the registers read as follows: index 0 (command) = 0, 1 = 0, 2 = 0, 3 (working count) = 0, 4 (working address) = 0xFFFFFFFF, 5 (status) = 0, 6 = 0, 7 (working descriptor address) = 0xFFFFFFFD. `dma_en` and `abort_o` are low after reset.
- R2: Writes to index 1 (starting count), 2 (starting address) and 6 (starting descriptor address) store all 32 bits. Writes to indices 3, 4 and 7 are dropped. A write to index 0 stores the whole word as the command. Command bits [1:0] select the operation: 0 idle, 1 flush (no action), 2 abort, 3 start. Bit 7 is the direction, where 1 means device to memory.
- R3: A start command makes index 3 equal to index 1, index 4 equal to index 2 and index 7 equal to index 6 from the next cycle. It clears status bits [5:0] and raises `dma_en` from the next cycle.
- R4: An idle command pulls `dma_en` low in the same cycle as the write, and `dma_en` stays low afterwards.
- R5: An abort command raises `abort_o` for exactly one cycle, in the cycle after the write.
- R6: `brst_ready` is high only while `dma_en` is high and no command write is in progress. When ready is low, or when `brst_dir` differs from command bit 7, `brst_grant` is 0 and the working registers do not change.
- R7: An accepted burst with matching direction is granted min(`brst_len`, working count). At the next edge the working count decreases by the grant and the working address increases by the grant. A working count of 0 gives a grant of 0.
- R8: A `cmd_done` pulse sets the working count to 0 and sets status bit 3 (done). Setting done takes priority over any clear of done in the same cycle.
- R9: With `stat_clr_rd` low, a write to index 5 clears each of status bits 1 (error), 2 (abort) and 3 (done) where the written data has a one. All other written bits have no effect.
- R10: With `stat_clr_rd` high, a read of index 5 returns the current value and then clears bits 1 to 3 at the next edge. Writes to index 5 have no effect in this mode.
- R11: Status bit 4 reads as the live `scsi_irq` input and is never stored.
- R12: `reg_rdata` shows the register selected by `reg_idx` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-on-read) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_idx` |
| stat_clr_rd | input | 1 | Status clear mode: 0 write-one-to-clear, 1 clear-on-read |
| scsi_irq | input | 1 | Live interrupt flag from the SCSI core |
| brst_valid | input | 1 | Burst request valid |
| brst_ready | output | 1 | Burst request can be taken |
| brst_dir | input | 1 | Burst direction, 1 = device to memory |
| brst_len | input | LW | Requested burst length in bytes |
| brst_grant | output | LW | Granted, clamped burst length |
| cmd_done | input | 1 | One-cycle command-complete pulse from the core |
| dma_en | output | 1 | DMA enable toward the SCSI core |
| abort_o | output | 1 | One-cycle request cancel toward the core |

## Verification
The hardest condition to reach is the clamp boundary, where the running working count falls below the requested length partway through a transfer. The stimulus reaches it with a sweep of burst lengths 0 to 15 against a starting count of 37. Their sum runs past the count, so the sweep covers exact grants, one partial grant and then zero grants, with the model checking count and address after every step. The two status clear modes are reached by raising done with `cmd_done` and then switching `stat_clr_rd` between reads and writes of the status register.

// File: rtl/scsi_dma_pkg.sv
`timescale 1ns/1ps
package scsi_dma_pkg;
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);

  // register indices (software-visible order)
  localparam int RI_CMD  = 0;
  localparam int RI_SCNT = 1;
  localparam int RI_SADR = 2;
  localparam int RI_WCNT = 3;
  localparam int RI_WADR = 4;
  localparam int RI_STAT = 5;
  localparam int RI_SDSC = 6;
  localparam int RI_WDSC = 7;

  // command word fields
  localparam int CB_DIR = 7;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_FLUSH  = 2'd1,
    OP_CANCEL = 2'd2,
    OP_GO     = 2'd3
  } dma_op_e;

  // status bit positions
  localparam int SB_PDN  = 0;
  localparam int SB_ERR  = 1;
  localparam int SB_ABT  = 2;
  localparam int SB_DONE = 3;
  localparam int SB_IRQ  = 4;
  localparam int SB_CMB  = 5;
endpackage

// File: rtl/dma_cmd_ctl.sv
`timescale 1ns/1ps
module dma_cmd_ctl
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output logic          start_p,
  output logic          dma_en,
  output logic          abort_o
);
  dma_op_e op;
  logic    idle_p;
  logic    cancel_p;
  logic    en_q;

  assign op       = dma_op_e'(wdata[1:0]);
  assign start_p  = cmd_wr && (op == OP_GO);
  assign idle_p   = cmd_wr && (op == OP_IDLE);
  assign cancel_p = cmd_wr && (op == OP_CANCEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      en_q    <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      if (start_p) en_q <= 1'b1;
      else if (idle_p) en_q <= 1'b0;
      abort_o <= cancel_p;
    end
  end

  // idle takes effect combinationally in the write cycle
  assign dma_en = en_q && !idle_p;
endmodule

// File: rtl/dma_stat_reg.sv
`timescale 1ns/1ps
module dma_stat_reg
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic          done_p,
  input  logic          wr_stat,
  input  logic          rd_stat,
  input  logic          clr_on_rd,
  input  logic [DW-1:0] wdata,
  input  logic          scsi_irq,
  output logic [DW-1:0] view
);
  localparam logic [DW-1:0] CLR_MASK =
    DW'((1 << SB_ERR) | (1 << SB_ABT) | (1 << SB_DONE));
  localparam logic [DW-1:0] GO_MASK =
    DW'((1 << SB_PDN) | (1 << SB_ERR) | (1 << SB_ABT) |
        (1 << SB_DONE) | (1 << SB_IRQ) | (1 << SB_CMB));
  localparam logic [DW-1:0] IRQ_BIT = DW'(1 << SB_IRQ);
  localparam logic [DW-1:0] DONE_BIT = DW'(1 << SB_DONE);

  logic [DW-1:0] stat_q;
  logic [DW-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (start_p)
      stat_d = stat_d & ~GO_MASK;
    else if (wr_stat && !clr_on_rd)
      stat_d = stat_d & ~(wdata & CLR_MASK);
    if (rd_stat && clr_on_rd)
      stat_d = stat_d & ~CLR_MASK;
    if (done_p)
      stat_d = stat_d | DONE_BIT;
    stat_d = stat_d & ~IRQ_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign view = stat_q | (scsi_irq ? IRQ_BIT : '0);
endmodule

// File: rtl/dma_burst_ctl.sv
`timescale 1ns/1ps
module dma_burst_ctl #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          valid,
  input  logic          ready,
  input  logic          dir,
  input  logic [LW-1:0] len,
  input  logic          cmd_dir,
  input  logic [DW-1:0] wcnt,
  output logic          take,
  output logic [LW-1:0] grant
);
  logic [DW-1:0] len_ext;
  logic [LW-1:0] clamp;

  assign len_ext = {{(DW-LW){1'b0}}, len};
  assign take    = valid && ready && (dir == cmd_dir);
  assign clamp   = (len_ext > wcnt) ? wcnt[LW-1:0] : len;
  assign grant   = take ? clamp : '0;
endmodule

// File: rtl/scsi_dma_chan.sv
`timescale 1ns/1ps
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [IW-1:0] reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          stat_clr_rd,
  input  logic          scsi_irq,
  input  logic          brst_valid,
  output logic          brst_ready,
  input  logic          brst_dir,
  input  logic [LW-1:0] brst_len,
  output logic [LW-1:0] brst_grant,
  input  logic          cmd_done,
  output logic          dma_en,
  output logic          abort_o
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WDSC_RST = ~DW'(2);

  logic [NREG-1:0] wsel;
  logic [DW-1:0]   cmd_q, stat_view;
  logic [DW-1:0]   scnt_q, sadr_q, sdsc_q;
  logic [DW-1:0]   wcnt_q, wadr_q, wdsc_q;
  logic            start_p, take;
  logic [DW-1:0]   grant_ext;
  logic [DW-1:0]   rbank [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_wsel
      assign wsel[g] = reg_wr && (reg_idx == IW'(g));
    end
  endgenerate

  dma_cmd_ctl #(.DW(DW)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (wsel[RI_CMD]),
    .wdata  (reg_wdata),
    .cmd_q  (cmd_q),
    .start_p(start_p),
    .dma_en (dma_en),
    .abort_o(abort_o)
  );

  dma_stat_reg #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_p  (start_p),
    .done_p   (cmd_done),
    .wr_stat  (wsel[RI_STAT]),
    .rd_stat  (reg_rd && (reg_idx == IW'(RI_STAT))),
    .clr_on_rd(stat_clr_rd),
    .wdata    (reg_wdata),
    .scsi_irq (scsi_irq),
    .view     (stat_view)
  );

  assign brst_ready = dma_en && !wsel[RI_CMD];

  dma_burst_ctl #(.DW(DW), .LW(LW)) u_brst (
    .valid  (brst_valid),
    .ready  (brst_ready),
    .dir    (brst_dir),
    .len    (brst_len),
    .cmd_dir(cmd_q[CB_DIR]),
    .wcnt   (wcnt_q),
    .take   (take),
    .grant  (brst_grant)
  );

  assign grant_ext = {{(DW-LW){1'b0}}, brst_grant};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
      wcnt_q <= '0;
      wadr_q <= WADR_RST;
      wdsc_q <= WDSC_RST;
    end else begin
      if (wsel[RI_SCNT]) scnt_q <= reg_wdata;
      if (wsel[RI_SADR]) sadr_q <= reg_wdata;
      if (wsel[RI_SDSC]) sdsc_q <= reg_wdata;

      if (cmd_done)     wcnt_q <= '0;
      else if (start_p) wcnt_q <= scnt_q;
      else if (take)    wcnt_q <= wcnt_q - grant_ext;

      if (start_p)      wadr_q <= sadr_q;
      else if (take)    wadr_q <= wadr_q + grant_ext;

      if (start_p)      wdsc_q <= sdsc_q;
    end
  end

  assign rbank[RI_CMD]  = cmd_q;
  assign rbank[RI_SCNT] = scnt_q;
  assign rbank[RI_SADR] = sadr_q;
  assign rbank[RI_WCNT] = wcnt_q;
  assign rbank[RI_WADR] = wadr_q;
  assign rbank[RI_STAT] = stat_view;
  assign rbank[RI_SDSC] = sdsc_q;
  assign rbank[RI_WDSC] = wdsc_q;

  assign reg_rdata = rbank[reg_idx];
endmodule

// File: rtl/scsi_dma_chan_chk.sv
`timescale 1ns/1ps
module scsi_dma_chan_chk
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [IW-1:0] reg_idx,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          scsi_irq,
  input logic          brst_valid,
  input logic          brst_ready,
  input logic          brst_dir,
  input logic [LW-1:0] brst_len,
  input logic [LW-1:0] brst_grant,
  input logic          cmd_done,
  input logic          dma_en,
  input logic          abort_o,
  input logic          cmd_dir
);
  logic cmd_w;
  assign cmd_w = reg_wr && (reg_idx == IW'(RI_CMD));

  p_start_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && reg_wdata[1:0] == 2'd3 |=> dma_en);

  p_idle_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && reg_wdata[1:0] == 2'd0 |-> !dma_en);

  p_abort_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  p_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !brst_ready |-> brst_grant == '0);

  p_dir_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brst_valid && (brst_dir != cmd_dir) |-> brst_grant == '0);

  p_grant_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brst_grant <= brst_len);

  p_done_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (reg_idx != IW'(RI_STAT)) || reg_rdata[SB_DONE]);

  p_irq_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == IW'(RI_STAT) |-> reg_rdata[SB_IRQ] == scsi_irq);
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .scsi_irq  (scsi_irq),
  .brst_valid(brst_valid),
  .brst_ready(brst_ready),
  .brst_dir  (brst_dir),
  .brst_len  (brst_len),
  .brst_grant(brst_grant),
  .cmd_done  (cmd_done),
  .dma_en    (dma_en),
  .abort_o   (abort_o),
  .cmd_dir   (cmd_q[7])
);

// File: tb/scsi_dma_chan_tb.sv
`timescale 1ns/1ps
module scsi_dma_chan_tb;
  localparam int DW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_idx = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          stat_clr_rd = 1'b0, scsi_irq = 1'b0;
  logic          brst_valid = 1'b0, brst_dir = 1'b0;
  logic          brst_ready;
  logic [LW-1:0] brst_len = '0;
  logic [LW-1:0] brst_grant;
  logic          cmd_done = 1'b0;
  logic          dma_en, abort_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  scsi_dma_chan #(.DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_clr_rd(stat_clr_rd), .scsi_irq(scsi_irq),
    .brst_valid(brst_valid), .brst_ready(brst_ready), .brst_dir(brst_dir),
    .brst_len(brst_len), .brst_grant(brst_grant), .cmd_done(cmd_done),
    .dma_en(dma_en), .abort_o(abort_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = 3'(idx);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic burst(input logic dir, input int len,
                       output logic [LW-1:0] g, output logic rdy);
    @(negedge clk);
    brst_valid = 1'b1; brst_dir = dir; brst_len = LW'(len);
    #1 g = brst_grant; rdy = brst_ready;
    @(negedge clk);
    brst_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [LW-1:0] g;
    logic rdy;
    int m_cnt, m_adr, gexp;
    logic [DW-1:0] rst_exp [8];

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rst_exp = '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFD};
    for (int i = 0; i < 8; i++) begin
      rd(i, d);
      chk($sformatf("R1 reset idx%0d", i), d, rst_exp[i]);
    end
    chk("R1 dma_en", {31'b0, dma_en}, 32'h0);
    chk("R1 abort_o", {31'b0, abort_o}, 32'h0);

    // R2 write sweep over data indices (command and status handled elsewhere)
    for (int i = 1; i < 8; i++) begin
      if (i != 5) wr(i, 32'hA500_0000 | (i << 8) | i);
    end
    for (int i = 1; i < 8; i++) begin
      if (i != 5) begin
        rd(i, d);
        if (i == 1 || i == 2 || i == 6)
          chk($sformatf("R2 stored idx%0d", i), d, 32'hA500_0000 | (i << 8) | i);
        else
          chk($sformatf("R2 dropped idx%0d", i), d, rst_exp[i]);
      end
    end
    wr(0, 32'h0000_0051);
    rd(0, d);
    chk("R2 command stored", d, 32'h51);
    chk("R2 flush leaves dma_en low", {31'b0, dma_en}, 32'h0);

    // R3 start
    wr(1, 37); wr(2, 32'h1000); wr(6, 32'h2000);
    wr(0, 32'h83);
    chk("R3 dma_en after start", {31'b0, dma_en}, 32'h1);
    rd(3, d); chk("R3 working count", d, 37);
    rd(4, d); chk("R3 working address", d, 32'h1000);
    rd(7, d); chk("R3 working descriptor", d, 32'h2000);
    rd(5, d); chk("R3 status cleared", d, 32'h0);

    // R6/R7 burst length sweep with clamp
    m_cnt = 37; m_adr = 32'h1000;
    for (int len = 0; len < 16; len++) begin
      burst(1'b1, len, g, rdy);
      gexp = (len < m_cnt) ? len : m_cnt;
      chk($sformatf("R6 ready len%0d", len), {31'b0, rdy}, 32'h1);
      chk($sformatf("R7 grant len%0d", len), {16'b0, g}, gexp);
      m_cnt -= gexp; m_adr += gexp;
      rd(3, d); chk($sformatf("R7 count len%0d", len), d, m_cnt);
      rd(4, d); chk($sformatf("R7 address len%0d", len), d, m_adr);
    end

    // R6 direction mismatch after restart
    wr(0, 32'h83);
    burst(1'b0, 5, g, rdy);
    chk("R6 mismatch grant", {16'b0, g}, 32'h0);
    rd(3, d); chk("R6 mismatch count kept", d, 37);
    rd(4, d); chk("R6 mismatch address kept", d, 32'h1000);

    // R8 command complete
    done_pulse();
    rd(3, d); chk("R8 count zeroed", d, 0);
    rd(5, d); chk("R8 done set", d, 32'h08);
    burst(1'b1, 9, g, rdy);
    chk("R7 zero count grant", {16'b0, g}, 32'h0);

    // R11 live interrupt overlay
    scsi_irq = 1'b1;
    rd(5, d); chk("R11 irq shown", d, 32'h18);
    scsi_irq = 1'b0;
    rd(5, d); chk("R11 irq not stored", d, 32'h08);

    // R9 write-one-to-clear
    stat_clr_rd = 1'b0;
    wr(5, 32'hFFFF_FFF0 & ~32'h0E);
    rd(5, d); chk("R9 unmasked bits ignored", d, 32'h08);
    wr(5, 32'h08);
    rd(5, d); chk("R9 done cleared", d, 32'h0);

    // R10 clear-on-read
    done_pulse();
    stat_clr_rd = 1'b1;
    wr(5, 32'h0E);
    rd(5, d); chk("R10 write ignored, read value", d, 32'h08);
    rd(5, d); chk("R10 cleared by read", d, 32'h0);
    stat_clr_rd = 1'b0;

    // R3 start clears done
    done_pulse();
    wr(0, 32'h83);
    rd(5, d); chk("R3 start clears done", d, 32'h0);

    // R12 same-cycle read
    @(negedge clk);
    reg_idx = 3'd1;
    #1 chk("R12 comb read idx1", reg_rdata, 37);
    reg_idx = 3'd7;
    #1 chk("R12 comb read idx7", reg_rdata, 32'h2000);

    // R4 idle in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h80;
    #1 chk("R4 dma_en drops in write cycle", {31'b0, dma_en}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 chk("R4 dma_en stays low", {31'b0, dma_en}, 32'h0);
    burst(1'b1, 3, g, rdy);
    chk("R6 ready low when disabled", {31'b0, rdy}, 32'h0);
    chk("R6 no grant when disabled", {16'b0, g}, 32'h0);

    // R5 abort pulse
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h82;
    #1 chk("R5 abort not yet", {31'b0, abort_o}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 chk("R5 abort high", {31'b0, abort_o}, 32'h1);
    @(negedge clk);
    #1 chk("R5 abort one cycle", {31'b0, abort_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule